// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache with Victim Store

This block is a write-back data cache placed between a processor request port and a word-wide main-memory port. Its main array is direct-mapped: the low address bits pick a word inside a line, the next bits pick the one line a block may occupy, and the remaining upper bits form the stored tag. Alongside the main array sits a small fully associative victim store. Lines pushed out of the main array go there rather than being dropped. A later access to such a line swaps it back into the main array in one operation, with no memory traffic.

The processor issues one access at a time through a valid/ready request channel. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low, and `stall` is high, from the edge that accepts a request until the cycle in which that access responds. The processor holds the request fields steady while `req_valid` is high and `req_ready` is low. The response is a single-cycle `rsp_valid` pulse and cannot be back-pressured. The memory channel moves one word per beat. `mem_req_valid`, `mem_we`, `mem_addr` and `mem_wdata` stay constant until a rising edge with `mem_ready` high completes the beat. On read beats, `mem_rdata` is sampled on that same edge.

With default parameters, an address is 10 bits. Bits [1:0] select one of 4 words, bits [4:2] select one of 8 lines, bits [9:5] are the tag, and the victim store holds 4 lines.

Top module: `dmv_cache`

## Requirements
- R1: An address splits into word offset `addr[OFF_W-1:0]`, line index `addr[OFF_W+IDX_W-1:OFF_W]` and tag `addr[ADDR_W-1:OFF_W+IDX_W]`. A block (address with the offset removed) can live only in main line number block mod 2^IDX_W. Two addresses with equal index and tag share one line.
- R2: Reset clears every valid bit in the main array and in the victim store, so the first access to any address after reset misses in both.
- R3: A read that hits the main array returns the stored word two edges after acceptance and causes no memory beat.
- R4: A write that hits updates only the cached word, marks the line dirty and causes no memory beat.
- R5: A miss in both structures reads the whole line from memory. It takes 2^OFF_W read beats at word addresses {block, 0} through {block, 2^OFF_W-1} in ascending order, then responds. A read responds with the requested memory word, which is also installed in the main line.
- R6: A write miss fetches the line first, then merges the write word into it and marks the line dirty. The other words of the line keep their memory values.
- R7: When a miss in both structures replaces a valid main line, that line (with its dirty state and data) moves into the victim store. It is not lost.
- R8: A main-array miss that hits the victim store swaps the two lines in one operation. The victim line enters the main array, and the displaced main line, if valid, takes the freed slot. The access is served from the swapped-in line with no memory beat.
- R9: A line entering the victim store takes the lowest-numbered free slot. When no slot is free, it takes the slot named by a round-robin pointer that starts at slot 0 after reset and advances after each such replacement, so that with no swaps in between the oldest entry goes first. A dirty entry leaving this way is first written to memory in 2^OFF_W ascending write beats. A clean one is dropped with no memory beat.
- R10: `req_ready` is high only while the block is idle, and `stall` is its complement. A memory beat request, once raised, keeps its address and direction until `mem_ready` completes it.
- R11: Each accepted request produces exactly one single-cycle `rsp_valid` pulse. `rsp_rdata` carries the read word, or for a write the word just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | WORD_W | Write word |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | WORD_W | Read word, or written word for writes |
| stall | output | 1 | High while an access is in progress |
| mem_req_valid | output | 1 | Memory beat requested |
| mem_ready | input | 1 | Memory completes the current beat |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | ADDR_W | Word address of the beat |
| mem_wdata | output | WORD_W | Write-beat data |
| mem_rdata | input | WORD_W | Read-beat data |

## Verification
The bench drives repeated conflicts on one line index. A dirty line must survive its move into the victim store and come back through a swap with its written word intact; a design that dropped displaced lines or lost their dirty state would return stale memory data there. It then fills the victim store until the round-robin replacement hits first a dirty entry and then a clean one. A wrong design would either skip the write-back, leaving stale words in memory that a later miss exposes, or write back clean data and show extra write beats. A write miss and hits with no memory traffic round out the checks, so that a design that writes through or refills on a hit shows up in the beat counts.

// File: rtl/dmv_pkg.sv
package dmv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WBACK,
    ST_FILL,
    ST_DONE
  } dmv_state_e;

endpackage

// File: rtl/dmv_line_array.sv
module dmv_line_array #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 5,
  parameter int LINE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic              wr_dirty,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line
);

  localparam int NLINES = 1 << IDX_W;

  logic [NLINES-1:0] valid_q;
  logic [NLINES-1:0] dirty_q;
  logic [TAG_W-1:0]  tag_q  [NLINES];
  logic [LINE_W-1:0] line_q [NLINES];

  // state bits: cleared by reset (R2)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= wr_valid;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  // payload: no reset needed, guarded by valid
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      line_q[wr_idx] <= wr_line;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_line  = line_q[rd_idx];

  // R4: a line can only be dirty while it is valid
  a_r4_dirty_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ((dirty_q & ~valid_q) == '0));

endmodule

// File: rtl/dmv_victim_store.sv
module dmv_victim_store #(
  parameter int N      = 4,
  parameter int BLK_W  = 8,
  parameter int LINE_W = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BLK_W-1:0]     lk_blk,
  output logic                 hit,
  output logic [$clog2(N)-1:0] hit_slot,
  output logic                 hit_dirty,
  output logic [LINE_W-1:0]    hit_line,
  output logic                 full,
  output logic [$clog2(N)-1:0] ins_slot,
  output logic                 ins_valid,
  output logic                 ins_dirty,
  output logic [BLK_W-1:0]     ins_blk,
  output logic [LINE_W-1:0]    ins_line,
  input  logic                 wr_en,
  input  logic [$clog2(N)-1:0] wr_slot,
  input  logic                 wr_valid,
  input  logic                 wr_dirty,
  input  logic [BLK_W-1:0]     wr_blk,
  input  logic [LINE_W-1:0]    wr_line,
  input  logic                 adv_ptr
);

  localparam int SLOT_W = $clog2(N);

  logic [N-1:0]      valid_q;
  logic [N-1:0]      dirty_q;
  logic [BLK_W-1:0]  blk_q  [N];
  logic [LINE_W-1:0] line_q [N];
  logic [SLOT_W-1:0] ptr_q;
  logic [N-1:0]      hit_vec;
  logic [SLOT_W-1:0] free_slot;

  // parallel compare against the full block number
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = valid_q[g] && (blk_q[g] == lk_blk);
  end

  always_comb begin
    hit_slot = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) hit_slot = SLOT_W'(i);
    end
  end

  // lowest-numbered free slot wins
  always_comb begin
    free_slot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_q[i]) free_slot = SLOT_W'(i);
    end
  end

  assign hit       = |hit_vec;
  assign hit_dirty = dirty_q[hit_slot];
  assign hit_line  = line_q[hit_slot];
  assign full      = &valid_q;
  assign ins_slot  = full ? ptr_q : free_slot;
  assign ins_valid = valid_q[ins_slot];
  assign ins_dirty = dirty_q[ins_slot];
  assign ins_blk   = blk_q[ins_slot];
  assign ins_line  = line_q[ins_slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      ptr_q   <= '0;
    end else begin
      if (wr_en) begin
        valid_q[wr_slot] <= wr_valid;
        dirty_q[wr_slot] <= wr_dirty;
      end
      if (adv_ptr) begin
        ptr_q <= (ptr_q == SLOT_W'(N - 1)) ? '0 : ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      blk_q[wr_slot]  <= wr_blk;
      line_q[wr_slot] <= wr_line;
    end
  end

  // R7: a block is never held in two victim slots at once
  a_r7_unique_block: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R9: pointer advances only when replacing into a full store
  a_r9_adv_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    adv_ptr |-> full);

endmodule

// File: rtl/dmv_cache.sv
module dmv_cache
  import dmv_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 16,
  parameter int OFF_W  = 2,
  parameter int IDX_W  = 3,
  parameter int VICT_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              stall,
  output logic              mem_req_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);

  localparam int BLK_W  = ADDR_W - OFF_W;
  localparam int TAG_W  = BLK_W - IDX_W;
  localparam int WPL    = 1 << OFF_W;
  localparam int LINE_W = WORD_W * WPL;
  localparam int SLOT_W = $clog2(VICT_N);

  function automatic logic [WORD_W-1:0] word_of(input logic [LINE_W-1:0] l,
                                                input logic [OFF_W-1:0]  o);
    return l[o*WORD_W +: WORD_W];
  endfunction

  function automatic logic [LINE_W-1:0] merge_word(input logic [LINE_W-1:0] l,
                                                   input logic [OFF_W-1:0]  o,
                                                   input logic [WORD_W-1:0] w);
    logic [LINE_W-1:0] t;
    t = l;
    t[o*WORD_W +: WORD_W] = w;
    return t;
  endfunction

  dmv_state_e        state_q;
  logic              r_we;
  logic [ADDR_W-1:0] r_addr;
  logic [WORD_W-1:0] r_wdata;
  logic [OFF_W-1:0]  beat_q;
  logic [LINE_W-1:0] fill_q;
  logic              rsp_valid_q;
  logic [WORD_W-1:0] rsp_data_q;

  // R1: address decode
  logic [OFF_W-1:0] r_off;
  logic [IDX_W-1:0] r_idx;
  logic [TAG_W-1:0] r_tag;
  logic [BLK_W-1:0] r_blk;
  assign r_off = r_addr[OFF_W-1:0];
  assign r_idx = r_addr[OFF_W +: IDX_W];
  assign r_tag = r_addr[ADDR_W-1 -: TAG_W];
  assign r_blk = r_addr[ADDR_W-1:OFF_W];

  // main array ports
  logic              m_valid, m_dirty;
  logic [TAG_W-1:0]  m_tag;
  logic [LINE_W-1:0] m_line;
  logic              a_we, a_valid, a_dirty;
  logic [TAG_W-1:0]  a_tag;
  logic [LINE_W-1:0] a_line;

  dmv_line_array #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W),
    .LINE_W(LINE_W)
  ) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (r_idx),
    .rd_valid(m_valid),
    .rd_dirty(m_dirty),
    .rd_tag  (m_tag),
    .rd_line (m_line),
    .wr_en   (a_we),
    .wr_idx  (r_idx),
    .wr_valid(a_valid),
    .wr_dirty(a_dirty),
    .wr_tag  (a_tag),
    .wr_line (a_line)
  );

  // victim store ports
  logic              v_hit, v_hit_dirty, v_full;
  logic [SLOT_W-1:0] v_hit_slot, v_ins_slot;
  logic [LINE_W-1:0] v_hit_line, v_ins_line;
  logic              v_ins_valid, v_ins_dirty;
  logic [BLK_W-1:0]  v_ins_blk;
  logic              v_we, v_valid, v_dirty, v_adv;
  logic [SLOT_W-1:0] v_slot;
  logic [BLK_W-1:0]  v_blk;
  logic [LINE_W-1:0] v_line;

  dmv_victim_store #(
    .N     (VICT_N),
    .BLK_W (BLK_W),
    .LINE_W(LINE_W)
  ) u_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_blk   (r_blk),
    .hit      (v_hit),
    .hit_slot (v_hit_slot),
    .hit_dirty(v_hit_dirty),
    .hit_line (v_hit_line),
    .full     (v_full),
    .ins_slot (v_ins_slot),
    .ins_valid(v_ins_valid),
    .ins_dirty(v_ins_dirty),
    .ins_blk  (v_ins_blk),
    .ins_line (v_ins_line),
    .wr_en    (v_we),
    .wr_slot  (v_slot),
    .wr_valid (v_valid),
    .wr_dirty (v_dirty),
    .wr_blk   (v_blk),
    .wr_line  (v_line),
    .adv_ptr  (v_adv)
  );

  logic main_hit, need_wb, last_beat;
  assign main_hit  = m_valid && (m_tag == r_tag);
  assign need_wb   = m_valid && v_ins_valid && v_ins_dirty;
  assign last_beat = (beat_q == OFF_W'(WPL - 1));

  // structure updates
  always_comb begin
    a_we    = 1'b0;
    a_valid = 1'b1;
    a_dirty = 1'b0;
    a_tag   = r_tag;
    a_line  = m_line;
    v_we    = 1'b0;
    v_slot  = v_ins_slot;
    v_valid = 1'b1;
    v_dirty = m_dirty;
    v_blk   = {m_tag, r_idx};
    v_line  = m_line;
    v_adv   = 1'b0;
    case (state_q)
      ST_LOOKUP: begin
        if (main_hit) begin
          if (r_we) begin
            // R4: write hit stays in the cache
            a_we    = 1'b1;
            a_dirty = 1'b1;
            a_line  = merge_word(m_line, r_off, r_wdata);
          end
        end else if (v_hit) begin
          // R8: swap main line and victim line
          a_we    = 1'b1;
          a_dirty = v_hit_dirty | r_we;
          a_line  = r_we ? merge_word(v_hit_line, r_off, r_wdata) : v_hit_line;
          v_we    = 1'b1;
          v_slot  = v_hit_slot;
          v_valid = m_valid;
        end else if (m_valid && !need_wb) begin
          // R7: displaced line enters the victim store
          v_we  = 1'b1;
          v_adv = v_full;
        end
      end
      ST_WBACK: begin
        if (mem_ready && last_beat) begin
          v_we  = 1'b1;
          v_adv = v_full;
        end
      end
      ST_DONE: begin
        // R5/R6: refilled line installed, write merged
        a_we    = 1'b1;
        a_dirty = r_we;
        a_line  = r_we ? merge_word(fill_q, r_off, r_wdata) : fill_q;
      end
      default: ;
    endcase
  end

  // control sequence
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      r_we        <= 1'b0;
      r_addr      <= '0;
      r_wdata     <= '0;
      beat_q      <= '0;
      fill_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            r_we    <= req_we;
            r_addr  <= req_addr;
            r_wdata <= req_wdata;
            state_q <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          beat_q <= '0;
          if (main_hit || v_hit) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= r_we ? r_wdata :
                           (main_hit ? word_of(m_line, r_off) : word_of(v_hit_line, r_off));
            state_q     <= ST_IDLE;
          end else if (need_wb) begin
            state_q <= ST_WBACK;
          end else begin
            state_q <= ST_FILL;
          end
        end
        ST_WBACK: begin
          if (mem_ready) begin
            beat_q <= beat_q + 1'b1;
            if (last_beat) state_q <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_ready) begin
            fill_q <= merge_word(fill_q, beat_q, mem_rdata);
            beat_q <= beat_q + 1'b1;
            if (last_beat) state_q <= ST_DONE;
          end
        end
        ST_DONE: begin
          rsp_valid_q <= 1'b1;
          rsp_data_q  <= r_we ? r_wdata : word_of(fill_q, r_off);
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign stall         = !req_ready;
  assign rsp_valid     = rsp_valid_q;
  assign rsp_rdata     = rsp_data_q;
  assign mem_req_valid = (state_q == ST_WBACK) || (state_q == ST_FILL);
  assign mem_we        = (state_q == ST_WBACK);
  assign mem_addr      = (state_q == ST_WBACK) ? {v_ins_blk, beat_q} : {r_blk, beat_q};
  assign mem_wdata     = word_of(v_ins_line, beat_q);

  // R3: a main hit leaves memory idle
  a_r3_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOOKUP && main_hit) |=> !mem_req_valid);

  // R8: a victim hit leaves memory idle
  a_r8_swap_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOOKUP && !main_hit && v_hit) |=> !mem_req_valid);

  // R9: only dirty victims are written back
  a_r9_wb_only_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_req_valid && v_ins_valid && v_ins_dirty));

  // R10: a pending memory beat is held stable
  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_ready) |=> (mem_req_valid && $stable(mem_addr) && $stable(mem_we)));

  // R10: acceptance raises stall on the next cycle
  a_r10_stall_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> stall);

  // R11: response strobe lasts one cycle
  a_r11_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: tb/dmv_cache_test.sv
module dmv_cache_test;

  localparam int AW = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          stall;
  logic          mem_req_valid;
  logic          mem_ready = 1'b0;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;

  dmv_cache uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_we       (req_we),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .stall        (stall),
    .mem_req_valid(mem_req_valid),
    .mem_ready    (mem_ready),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_rdata    (mem_rdata)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int errors = 0;
  int rd_beats = 0;
  int wr_beats = 0;
  int rsp_cnt = 0;
  int last_rd = 0;
  int last_wr = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [DW-1:0] bmem  [1 << AW];
  logic [DW-1:0] truth [1 << AW];
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];

  function automatic logic [DW-1:0] init_word(input int a);
    return DW'(a * 7 + 16'h1000);
  endfunction

  // R1: address = {tag[4:0], index[2:0], offset[1:0]}
  function automatic logic [AW-1:0] mk(input int t, input int i, input int o);
    return {t[4:0], i[2:0], o[1:0]};
  endfunction

  // memory model with irregular ready
  assign mem_rdata = bmem[mem_addr];
  always @(negedge clk) begin
    cyc <= cyc + 1;
    mem_ready <= (cyc % 3) != 0;
  end
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < (1 << AW); i++) bmem[i] <= init_word(i);
    end else if (mem_req_valid && mem_ready) begin
      if (mem_we) begin
        bmem[mem_addr] <= mem_wdata;
        wr_beats <= wr_beats + 1;
        last_wr  <= int'(mem_addr);
      end else begin
        rd_beats <= rd_beats + 1;
        last_rd  <= int'(mem_addr);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected responses (R11)
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      rsp_cnt = rsp_cnt + 1;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected response: actual %0h expected none", rsp_rdata);
      end else begin
        automatic logic [DW-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rsp_rdata !== e) begin
          errors++;
          $display("FAIL %s data: actual %0h expected %0h", t, rsp_rdata, e);
        end
      end
    end
  end

  // driver: pushes expectation, runs access, checks memory traffic
  task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int erd, input int ewr, input string tag);
    int rd0, wr0, n0;
    if (we) truth[a] = d;
    exp_q.push_back(we ? d : truth[a]);
    tag_q.push_back(tag);
    rd0 = rd_beats;
    wr0 = wr_beats;
    n0  = rsp_cnt;
    @(negedge clk);
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = a;
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk({"R10 stall after accept ", tag}, int'(stall), 1);
    while (rsp_cnt == n0) @(negedge clk);
    @(negedge clk);
    chk({"R11 one response ", tag}, rsp_cnt - n0, 1);
    chk({tag, " read beats"}, rd_beats - rd0, erd);
    chk({tag, " write beats"}, wr_beats - wr0, ewr);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) truth[i] = init_word(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2/R10: reset state
    chk("R10 reset req_ready", int'(req_ready), 1);
    chk("R10 reset stall", int'(stall), 0);
    chk("R11 reset rsp_valid", int'(rsp_valid), 0);
    chk("R2 reset mem idle", int'(mem_req_valid), 0);

    // R2/R5: first access misses, full ascending refill
    access(1'b0, mk(0, 1, 2), '0, 4, 0, "R5 cold read miss");
    chk("R5 last fill address", last_rd, int'(mk(0, 1, 3)));
    // R1/R3: other offset of same block hits
    access(1'b0, mk(0, 1, 0), '0, 0, 0, "R1 R3 read hit other offset");
    // R4: write hit stays local
    access(1'b1, mk(0, 1, 1), 16'hBEEF, 0, 0, "R4 write hit");
    access(1'b0, mk(0, 1, 1), '0, 0, 0, "R4 read back write hit");
    chk("R4 memory untouched", int'(bmem[mk(0, 1, 1)]), int'(init_word(int'(mk(0, 1, 1)))));
    // R1/R7: conflicting block, dirty line moves to victim
    access(1'b0, mk(1, 1, 0), '0, 4, 0, "R7 conflict miss");
    // R8: swap back from victim with dirty data intact
    access(1'b0, mk(0, 1, 1), '0, 0, 0, "R8 victim hit dirty");
    access(1'b0, mk(1, 1, 3), '0, 0, 0, "R8 victim hit swap back");
    // R6: write miss allocate
    access(1'b1, mk(2, 2, 3), 16'hCAFE, 4, 0, "R6 write miss");
    access(1'b0, mk(2, 2, 3), '0, 0, 0, "R6 merged word hit");
    access(1'b0, mk(2, 2, 1), '0, 0, 0, "R6 other word from memory");
    // R9: fill victim store (slot0 dirty A, then B, T2, T3)
    access(1'b0, mk(2, 1, 0), '0, 4, 0, "R9 fill victim 2");
    access(1'b0, mk(3, 1, 0), '0, 4, 0, "R9 fill victim 3");
    access(1'b0, mk(4, 1, 0), '0, 4, 0, "R9 fill victim 4");
    // R9: full, oldest is dirty -> write back then fill
    access(1'b0, mk(5, 1, 0), '0, 4, 4, "R9 dirty eviction");
    chk("R9 written back word", int'(bmem[mk(0, 1, 1)]), 16'hBEEF);
    chk("R9 last write-back address", last_wr, int'(mk(0, 1, 3)));
    // R9: next oldest clean -> dropped silently
    access(1'b0, mk(6, 1, 0), '0, 4, 0, "R9 clean eviction");
    // R9/R5: evicted dirty data now comes from memory
    access(1'b0, mk(0, 1, 1), '0, 4, 0, "R9 refetch after write-back");
    // R8: surviving victim entry still hits
    access(1'b0, mk(4, 1, 2), '0, 0, 0, "R8 victim hit after churn");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule